// File: doc/BRIEF.md
# Staged Panel Timing Sequencer

This block drives the timing side of a parallel RGB panel. A divider gives a pixel clock enable. Horizontal and vertical counters advance on that enable and produce the horizontal and vertical sync pulses, a data-enable window and a display-on level. A plain write port (strobe, 3-bit address, 32-bit data) loads a shadow copy of the timing fields. The shadow copy is moved to the live copy whenever the sync stage is off, and otherwise only at the edge that wraps the last pixel of a frame. A frame is therefore always drawn with one set of timing.

Panel power-up and power-down are split into four stages, each with its own status bit. The index order is bit 0 pixel clock, bit 1 sync, bit 2 display signal, bit 3 backlight PWM gate. Each stage has a one-cycle enable strobe and a one-cycle disable strobe.

Bring-up must run pixel clock, then sync, then display, then PWM. Shutdown must run display, then sync, then pixel clock, then PWM. A strobe that breaks this order is dropped and raises a one-cycle error pulse.

When the display is enabled, it first waits a programmed number of frame wraps (the guard time). Stopping the display or the sync stage takes effect at the next frame wrap, so no frame is cut short.

The stage controller is a state machine with these states:
- `LV_OFF`: everything is off.
- `LV_CLK`: only the clock is running.
- `LV_SYNC`: sync pulses run, display is off.
- `LV_GUARD`: waiting out the guard frames.
- `LV_DISP`: display is on.
- `LV_DISP_STOP`: display stays on until the frame wraps.
- `LV_SYNC_STOP`: sync stays on until the frame wraps.

Its transitions are:
- OFF→CLK on a clock enable.
- CLK→SYNC on a sync enable; CLK→OFF on a clock disable.
- SYNC→GUARD on a display enable; SYNC→SYNC_STOP on a sync disable.
- GUARD→DISP when the guard count is zero.
- GUARD→SYNC on a display disable, which aborts the wait.
- GUARD→SYNC_STOP on a sync disable.
- DISP→DISP_STOP on a display disable.
- DISP_STOP→SYNC on a frame wrap.
- SYNC_STOP→CLK on a frame wrap.

The PWM gate is a separate flag.

Top module: `lcd_timing_seq`

## Requirements
- R1: After reset, the outputs are as follows.
  - `stage_sts`, `cmd_err`, `pix_ce`, `de`, `disp_on` and `pwm_en` are 0.
  - `hsync` and `vsync` are 0.
  - The reset timing is: divide ratio 2, sync widths 1, porches 1 (vertical back porch 0), 4 pixels by 2 rows, no inversion, guard 1.
- R2: A stage enable strobe is accepted only if the status bit of the preceding stage is set. The clock stage needs nothing. Sync needs status bit 0. Display needs bit 1. PWM needs bit 2. A rejected enable changes no status, and `cmd_err` is 1 in the cycle after the strobe.
- R3: A disable strobe is accepted only if it follows the shutdown order. Display may always be disabled. Sync needs status bit 2 clear. The clock stage needs bit 1 clear. PWM needs bit 0 clear. A rejected disable changes no status and pulses `cmd_err` in the cycle after the strobe.
- R4: If more than one of the eight strobes is high in the same cycle, all of them are rejected with `cmd_err`.
- R5: While status bit 0 is set, `pix_ce` pulses once every divider-field + 2 cycles. If the bypass bit is set, it is high every cycle. While status bit 0 is clear, `pix_ce` stays 0.
- R6: A line lasts the sum of sync width, back porch, active pixels and front porch pixel periods. Each of these is programmed as its count minus one. `hsync` is active for the sync-width pixel periods at the start of each line.
- R7: A frame lasts the sum of vertical sync width, back porch, rows and front porch lines. The vertical back porch is programmed as its count; the other three are programmed as count minus one. `vsync` is active for the vertical sync-width lines at the start of each frame.
- R8: `de` is high only while `disp_on` is high, on active rows, from sync width + back porch pixel periods into the line, for the active-pixel periods.
- R9: After an accepted display enable, `disp_on` and status bit 2 rise one cycle after the guard-field-th frame wrap. With a guard of 0 they rise two cycles after the strobe.
- R10: An accepted display disable keeps `disp_on` high until the frame wraps. An accepted sync disable keeps the sync stage running until the frame wraps. After that the sync stage stops and status bit 1 clears.
- R11: A shadow write reaches the live timing as follows. With the sync stage off, it takes effect one cycle after the write. With the sync stage running, it takes effect only at the next frame wrap; the current frame keeps the old timing.
- R12: Mode bit 0 inverts `hsync` and mode bit 1 inverts `vsync`. While status bit 1 is clear, each sync output rests at its inactive level, which equals its inversion bit.
- R13: The write map is as follows.
  - Address 0: divider in bits 7:0, bypass in bit 16.
  - Address 1: horizontal sync width in bits 7:0, vertical sync width in bits 23:16.
  - Address 2: horizontal back porch in bits 7:0, horizontal front porch in bits 23:16.
  - Address 3: vertical back porch in bits 7:0, vertical front porch in bits 23:16.
  - Address 4: pixels per line in bits 10:0, rows per frame in bits 26:16.
  - Address 5: inversion bits in bits 1:0, guard frames in bits 11:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Shadow register write strobe |
| cfg_addr | input | 3 | Shadow register address |
| cfg_wdata | input | 32 | Shadow register data |
| stage_en | input | 4 | Stage enable strobes (0 clock, 1 sync, 2 display, 3 PWM) |
| stage_dis | input | 4 | Stage disable strobes, same indexing |
| stage_sts | output | 4 | Stage status, same indexing |
| cmd_err | output | 1 | One-cycle pulse for a rejected strobe |
| pix_ce | output | 1 | Pixel clock enable |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| de | output | 1 | Data enable |
| disp_on | output | 1 | Display signal |
| pwm_en | output | 1 | Backlight PWM gate |

## Verification
Each result has a fixed cycle at which it is due, and the bench samples there:
- Status bits and `cmd_err` are registered on the edge that captures a strobe. They are checked on the falling edge one cycle after the strobe.
- `hsync`, `vsync` and `de` are decoded from registered counters. Frames are measured from a `vsync` rise sampled on the falling edge, so every width and offset is an exact multiple of the pixel period. Expected values are computed from the programmed counts.
- The first frame after sync starts and the frame in which new timing is written are never used as the reference for new values.
- The guard is checked by counting frame wraps until `disp_on` is seen.

// File: rtl/lcd_seq_pkg.sv
package lcd_seq_pkg;
    localparam int unsigned DW      = 32;
    localparam int unsigned AW      = 3;
    localparam int unsigned DIVW    = 8;
    localparam int unsigned PW      = 8;
    localparam int unsigned HCW     = 11;
    localparam int unsigned GW      = 4;
    localparam int unsigned NSTG    = 4;
    localparam int unsigned HI_POS  = 16;
    localparam int unsigned G_POS   = 8;

    localparam logic [AW-1:0] A_CLK    = 3'd0;
    localparam logic [AW-1:0] A_SYNCW  = 3'd1;
    localparam logic [AW-1:0] A_HPORCH = 3'd2;
    localparam logic [AW-1:0] A_VPORCH = 3'd3;
    localparam logic [AW-1:0] A_SIZE   = 3'd4;
    localparam logic [AW-1:0] A_MODE   = 3'd5;

    localparam int unsigned S_CLK  = 0;
    localparam int unsigned S_SYNC = 1;
    localparam int unsigned S_DISP = 2;
    localparam int unsigned S_PWM  = 3;

    typedef struct packed {
        logic [DIVW-1:0] div_m2;
        logic            bypass;
        logic [PW-1:0]   hsw_m1;
        logic [PW-1:0]   vsw_m1;
        logic [PW-1:0]   hbp_m1;
        logic [PW-1:0]   hfp_m1;
        logic [PW-1:0]   vbp;
        logic [PW-1:0]   vfp_m1;
        logic [HCW-1:0]  ppl_m1;
        logic [HCW-1:0]  rpf_m1;
        logic            hpol;
        logic            vpol;
        logic [GW-1:0]   guard;
    } tcfg_t;

    typedef enum logic [2:0] {
        LV_OFF, LV_CLK, LV_SYNC, LV_GUARD, LV_DISP, LV_DISP_STOP, LV_SYNC_STOP
    } lv_state_e;

    function automatic tcfg_t cfg_reset();
        tcfg_t c;
        c = '0;
        c.ppl_m1 = HCW'(3);
        c.rpf_m1 = HCW'(1);
        c.guard  = GW'(1);
        return c;
    endfunction
endpackage

// File: rtl/lcd_cfg_regs.sv
module lcd_cfg_regs
    import lcd_seq_pkg::*;
(
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    input  logic          load,
    output tcfg_t         act
);
    tcfg_t shadow;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shadow <= cfg_reset();
        end else if (we) begin
            unique case (addr)
                A_CLK: begin
                    shadow.div_m2 <= wdata[DIVW-1:0];
                    shadow.bypass <= wdata[HI_POS];
                end
                A_SYNCW: begin
                    shadow.hsw_m1 <= wdata[PW-1:0];
                    shadow.vsw_m1 <= wdata[HI_POS +: PW];
                end
                A_HPORCH: begin
                    shadow.hbp_m1 <= wdata[PW-1:0];
                    shadow.hfp_m1 <= wdata[HI_POS +: PW];
                end
                A_VPORCH: begin
                    shadow.vbp    <= wdata[PW-1:0];
                    shadow.vfp_m1 <= wdata[HI_POS +: PW];
                end
                A_SIZE: begin
                    shadow.ppl_m1 <= wdata[HCW-1:0];
                    shadow.rpf_m1 <= wdata[HI_POS +: HCW];
                end
                A_MODE: begin
                    shadow.hpol  <= wdata[0];
                    shadow.vpol  <= wdata[1];
                    shadow.guard <= wdata[G_POS +: GW];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            act <= cfg_reset();
        end else if (load) begin
            act <= shadow;
        end
    end
endmodule

// File: rtl/lcd_pix_div.sv
module lcd_pix_div #(
    parameter int unsigned DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            run,
    input  logic            bypass,
    input  logic [DIVW-1:0] div_m2,
    output logic            ce
);
    localparam int unsigned CW = DIVW + 1;

    logic [CW-1:0] cnt;
    logic [CW-1:0] ratio_m1;

    always_comb begin
        ratio_m1 = CW'(div_m2) + CW'(1);
        ce       = run && (bypass || (cnt >= ratio_m1));
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || bypass || ce) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + CW'(1);
        end
    end

    // R5: without bypass a pulse is never followed by another one
    a_r5_ce_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (ce && !bypass) |=> (!ce || bypass));
endmodule

// File: rtl/lcd_stage_seq.sv
module lcd_stage_seq
    import lcd_seq_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NSTG-1:0] en_cmd,
    input  logic [NSTG-1:0] dis_cmd,
    input  logic            frame_end,
    input  logic [GW-1:0]   guard,
    output logic [NSTG-1:0] status,
    output logic            cmd_err,
    output logic            sync_run,
    output logic            disp_on
);
    lv_state_e       state, state_n;
    logic            pwm_q;
    logic [GW-1:0]   gcnt;
    logic            sts_clk, sts_sync, sts_disp;
    logic [NSTG-1:0] en_ok, dis_ok, take_en, take_dis;
    logic            multi, bad;

    always_comb begin
        sts_clk  = (state != LV_OFF);
        sts_sync = (state == LV_SYNC) || (state == LV_GUARD) || (state == LV_DISP) ||
                   (state == LV_DISP_STOP) || (state == LV_SYNC_STOP);
        sts_disp = (state == LV_DISP) || (state == LV_DISP_STOP);
        en_ok[S_CLK]   = 1'b1;
        en_ok[S_SYNC]  = sts_clk;
        en_ok[S_DISP]  = sts_sync;
        en_ok[S_PWM]   = sts_disp;
        dis_ok[S_DISP] = 1'b1;
        dis_ok[S_SYNC] = !sts_disp;
        dis_ok[S_CLK]  = !sts_sync;
        dis_ok[S_PWM]  = !sts_clk;
        multi    = ($countones({en_cmd, dis_cmd}) > 1);
        bad      = multi || (|(en_cmd & ~en_ok)) || (|(dis_cmd & ~dis_ok));
        take_en  = bad ? '0 : en_cmd;
        take_dis = bad ? '0 : dis_cmd;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            LV_OFF:       if (take_en[S_CLK]) state_n = LV_CLK;
            LV_CLK: begin
                if (take_en[S_SYNC])      state_n = LV_SYNC;
                else if (take_dis[S_CLK]) state_n = LV_OFF;
            end
            LV_SYNC: begin
                if (take_en[S_DISP])       state_n = LV_GUARD;
                else if (take_dis[S_SYNC]) state_n = LV_SYNC_STOP;
            end
            LV_GUARD: begin
                if (take_dis[S_DISP])      state_n = LV_SYNC;
                else if (take_dis[S_SYNC]) state_n = LV_SYNC_STOP;
                else if (gcnt == '0)       state_n = LV_DISP;
            end
            LV_DISP:      if (take_dis[S_DISP]) state_n = LV_DISP_STOP;
            LV_DISP_STOP: if (frame_end) state_n = LV_SYNC;
            LV_SYNC_STOP: if (frame_end) state_n = LV_CLK;
            default:      state_n = LV_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state   <= LV_OFF;
            pwm_q   <= 1'b0;
            gcnt    <= '0;
            cmd_err <= 1'b0;
        end else begin
            state   <= state_n;
            cmd_err <= bad;
            if (take_en[S_PWM])       pwm_q <= 1'b1;
            else if (take_dis[S_PWM]) pwm_q <= 1'b0;
            if (state == LV_SYNC && state_n == LV_GUARD)
                gcnt <= guard;
            else if (state == LV_GUARD && frame_end && gcnt != '0)
                gcnt <= gcnt - GW'(1);
        end
    end

    always_comb begin
        status[S_CLK]  = sts_clk;
        status[S_SYNC] = sts_sync;
        status[S_DISP] = sts_disp;
        status[S_PWM]  = pwm_q;
        sync_run       = sts_sync;
        disp_on        = sts_disp;
    end

    a_r2_sync_after_clk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[S_SYNC]) |-> $past(status[S_CLK]));
    a_r2_disp_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[S_DISP]) |-> $past(status[S_SYNC]));
    a_r2_pwm_after_disp: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(status[S_PWM]) |-> $past(status[S_DISP]));
    a_r3_clk_off_after_sync: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[S_CLK]) |-> !$past(status[S_SYNC]));
    a_r3_pwm_off_after_clk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[S_PWM]) |-> !$past(status[S_CLK]));
    a_r10_disp_stops_at_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(status[S_DISP]) |-> $past(frame_end));
    a_r4_multi_rejected: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones({en_cmd, dis_cmd}) > 1) |=> (cmd_err && $stable(status[S_PWM])));
endmodule

// File: rtl/lcd_raster.sv
module lcd_raster
    import lcd_seq_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  run,
    input  logic  ce,
    input  logic  disp_on,
    input  tcfg_t cfg,
    output logic  hsync,
    output logic  vsync,
    output logic  de,
    output logic  frame_end
);
    localparam int unsigned TW = HCW + 2;

    logic [TW-1:0] h, v;
    logic [TW-1:0] h_act_s, h_act_e, h_tot_m1, hsw;
    logic [TW-1:0] v_act_s, v_act_e, v_tot_m1, vsw;
    logic          h_last, v_last, hs_act, vs_act, h_in, v_in;

    always_comb begin
        hsw      = TW'(cfg.hsw_m1) + TW'(1);
        h_act_s  = hsw + TW'(cfg.hbp_m1) + TW'(1);
        h_act_e  = h_act_s + TW'(cfg.ppl_m1) + TW'(1);
        h_tot_m1 = h_act_e + TW'(cfg.hfp_m1);
        vsw      = TW'(cfg.vsw_m1) + TW'(1);
        v_act_s  = vsw + TW'(cfg.vbp);
        v_act_e  = v_act_s + TW'(cfg.rpf_m1) + TW'(1);
        v_tot_m1 = v_act_e + TW'(cfg.vfp_m1);
        h_last    = (h >= h_tot_m1);
        v_last    = (v >= v_tot_m1);
        frame_end = run && ce && h_last && v_last;
        hs_act    = run && (h < hsw);
        vs_act    = run && (v < vsw);
        h_in      = (h >= h_act_s) && (h < h_act_e);
        v_in      = (v >= v_act_s) && (v < v_act_e);
        hsync     = hs_act ^ cfg.hpol;
        vsync     = vs_act ^ cfg.vpol;
        de        = run && disp_on && h_in && v_in;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h <= '0;
            v <= '0;
        end else if (!run) begin
            h <= '0;
            v <= '0;
        end else if (ce) begin
            if (h_last) begin
                h <= '0;
                v <= v_last ? '0 : v + TW'(1);
            end else begin
                h <= h + TW'(1);
            end
        end
    end

    // R8: the data window never overlaps a sync pulse
    a_r8_de_clear_of_sync: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> (!hs_act && !vs_act));
endmodule

// File: rtl/lcd_timing_seq.sv
module lcd_timing_seq
    import lcd_seq_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_we,
    input  logic [2:0]  cfg_addr,
    input  logic [31:0] cfg_wdata,
    input  logic [3:0]  stage_en,
    input  logic [3:0]  stage_dis,
    output logic [3:0]  stage_sts,
    output logic        cmd_err,
    output logic        pix_ce,
    output logic        hsync,
    output logic        vsync,
    output logic        de,
    output logic        disp_on,
    output logic        pwm_en
);
    tcfg_t act_cfg;
    logic  sync_run, frame_end, load;

    assign load   = !sync_run || frame_end;
    assign pwm_en = stage_sts[S_PWM];

    lcd_cfg_regs i_regs (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr),
        .wdata(cfg_wdata), .load(load), .act(act_cfg)
    );

    lcd_pix_div #(.DIVW(DIVW)) i_div (
        .clk(clk), .rst_n(rst_n), .run(stage_sts[S_CLK]),
        .bypass(act_cfg.bypass), .div_m2(act_cfg.div_m2), .ce(pix_ce)
    );

    lcd_stage_seq i_seq (
        .clk(clk), .rst_n(rst_n), .en_cmd(stage_en), .dis_cmd(stage_dis),
        .frame_end(frame_end), .guard(act_cfg.guard), .status(stage_sts),
        .cmd_err(cmd_err), .sync_run(sync_run), .disp_on(disp_on)
    );

    lcd_raster i_ras (
        .clk(clk), .rst_n(rst_n), .run(sync_run), .ce(pix_ce),
        .disp_on(disp_on), .cfg(act_cfg), .hsync(hsync), .vsync(vsync),
        .de(de), .frame_end(frame_end)
    );

    a_r5_no_ce_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !stage_sts[S_CLK] |-> !pix_ce);
    a_r8_de_needs_disp: assert property (@(posedge clk) disable iff (!rst_n)
        de |-> disp_on);
    a_r11_cfg_steady_in_frame: assert property (@(posedge clk) disable iff (!rst_n)
        (sync_run && $past(sync_run) && !$past(frame_end)) |-> $stable(act_cfg));
endmodule

// File: tb/test_lcd_timing_seq.sv
module test_lcd_timing_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [2:0]  cfg_addr = '0;
    logic [31:0] cfg_wdata = '0;
    logic [3:0]  stage_en = '0;
    logic [3:0]  stage_dis = '0;
    logic [3:0]  stage_sts;
    logic        cmd_err, pix_ce, hsync, vsync, de, disp_on, pwm_en;

    int n_run = 0;
    int n_fail = 0;
    int m_div, m_byp, m_hsw, m_hbp, m_ppl, m_hfp, m_vsw, m_vbp, m_rows, m_vfp;
    int m_hpol, m_vpol, m_guard, m_disp;

    always #5 clk = ~clk;

    lcd_timing_seq i_lcd_timing_seq (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .stage_en(stage_en), .stage_dis(stage_dis),
        .stage_sts(stage_sts), .cmd_err(cmd_err), .pix_ce(pix_ce),
        .hsync(hsync), .vsync(vsync), .de(de), .disp_on(disp_on), .pwm_en(pwm_en)
    );

    task automatic chk(string req, string what, int act, int exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic int ratio();  return m_byp ? 1 : m_div + 2; endfunction
    function automatic int htot();   return m_hsw + m_hbp + m_ppl + m_hfp; endfunction
    function automatic int vtot();   return m_vsw + m_vbp + m_rows + m_vfp; endfunction
    function automatic logic vact(); return vsync ^ m_vpol[0]; endfunction
    function automatic logic hact(); return hsync ^ m_hpol[0]; endfunction

    task automatic wr(logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    // R13 field positions
    task automatic write_cfg();
        wr(3'd0, (32'(m_byp) << 16) | 32'(m_div));
        wr(3'd1, (32'(m_vsw - 1) << 16) | 32'(m_hsw - 1));
        wr(3'd2, (32'(m_hfp - 1) << 16) | 32'(m_hbp - 1));
        wr(3'd3, (32'(m_vfp - 1) << 16) | 32'(m_vbp));
        wr(3'd4, (32'(m_rows - 1) << 16) | 32'(m_ppl - 1));
        wr(3'd5, (32'(m_guard) << 8) | (32'(m_vpol) << 1) | 32'(m_hpol));
    endtask

    task automatic strobe(logic [3:0] en, logic [3:0] dis);
        @(negedge clk);
        stage_en = en; stage_dis = dis;
        @(negedge clk);
        stage_en = '0; stage_dis = '0;
    endtask

    task automatic wait_vrise();
        logic p;
        p = vact();
        while (1) begin
            @(negedge clk);
            if (!p && vact()) break;
            p = vact();
        end
    endtask

    task automatic ce_period(output int p);
        @(negedge clk);
        while (!pix_ce) @(negedge clk);
        p = 0;
        do begin
            @(negedge clk);
            p++;
        end while (!pix_ce);
    endtask

    // called at the falling edge where a vsync rise has just been seen
    task automatic measure_frame(int wr_at, logic [2:0] wa, logic [31:0] wd);
        int n = 0, de_c = 0, hr = 0, hw = 0, first_de = -1;
        logic hp = 1'b0, vp = 1'b1, in_first = 1'b1;
        int r = ratio();
        while (1) begin
            if (hact() && (n == 0 || !hp)) hr++;
            if (in_first) begin
                if (hact()) hw++; else in_first = 1'b0;
            end
            if (de) begin
                de_c++;
                if (first_de < 0) first_de = n;
            end
            hp = hact(); vp = vact();
            if (n == wr_at) begin
                cfg_we = 1'b1; cfg_addr = wa; cfg_wdata = wd;
            end else begin
                cfg_we = 1'b0;
            end
            @(negedge clk);
            n++;
            if (!vp && vact()) break;
        end
        cfg_we = 1'b0;
        chk("R7", "frame length cycles", n, htot() * vtot() * r);
        chk("R7", "lines per frame", hr, vtot());
        chk("R6", "hsync width cycles", hw, m_hsw * r);
        chk("R8", "de cycles per frame", de_c, m_disp ? m_ppl * m_rows * r : 0);
        chk("R8", "first de offset", first_de,
            m_disp ? ((m_vsw + m_vbp) * htot() + m_hsw + m_hbp) * r : -1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_run++; n_fail++;
        $display("FAIL watchdog actual=150000 cycles expected=earlier finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        int p, cnt, dummy;
        dummy = $urandom(5150);
        m_div = 0; m_byp = 0; m_hsw = 2; m_hbp = 1; m_ppl = 4; m_hfp = 1;
        m_vsw = 1; m_vbp = 1; m_rows = 3; m_vfp = 1;
        m_hpol = 0; m_vpol = 0; m_guard = 1; m_disp = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "status", int'(stage_sts), 0);
        chk("R1", "cmd_err", int'(cmd_err), 0);
        chk("R1", "pix_ce", int'(pix_ce), 0);
        chk("R1", "hsync/vsync", int'({hsync, vsync}), 0);
        chk("R1", "de/disp_on/pwm_en", int'({de, disp_on, pwm_en}), 0);

        write_cfg();
        strobe(4'b0010, 4'b0000);
        chk("R2", "sync enable before clock err", int'(cmd_err), 1);
        chk("R2", "status unchanged", int'(stage_sts), 0);
        strobe(4'b0100, 4'b0000);
        chk("R2", "display enable early err", int'(cmd_err), 1);
        strobe(4'b1000, 4'b0000);
        chk("R2", "pwm enable early err", int'(cmd_err), 1);
        chk("R5", "no pix_ce with clock off", int'(pix_ce), 0);
        strobe(4'b0001, 4'b0000);
        chk("R2", "clock enabled", int'(stage_sts), 1);
        chk("R2", "no err on accepted", int'(cmd_err), 0);
        strobe(4'b0010, 4'b0001);
        chk("R4", "two strobes err", int'(cmd_err), 1);
        chk("R4", "two strobes status", int'(stage_sts), 1);

        ce_period(p);
        chk("R5", "pix_ce period ratio 2", p, 2);
        wr(3'd0, 32'd3);
        repeat (2) @(negedge clk);
        ce_period(p); ce_period(p);
        chk("R11", "divider loaded while sync off", p, 5);
        wr(3'd0, 32'h0001_0000);
        repeat (2) @(negedge clk);
        ce_period(p);
        chk("R5", "bypass every cycle", p, 1);
        write_cfg();
        repeat (2) @(negedge clk);

        wr(3'd5, 32'h0000_0103);
        repeat (2) @(negedge clk);
        chk("R12", "idle sync level inverted", int'({hsync, vsync}), 3);
        wr(3'd5, 32'h0000_0100);
        repeat (2) @(negedge clk);
        chk("R12", "idle sync level plain", int'({hsync, vsync}), 0);

        strobe(4'b0010, 4'b0000);
        chk("R2", "sync enabled", int'(stage_sts), 3);
        wait_vrise(); wait_vrise();
        measure_frame(-1, 3'd0, 32'd0);
        strobe(4'b0000, 4'b0001);
        chk("R3", "clock disable with sync on err", int'(cmd_err), 1);
        chk("R3", "status kept", int'(stage_sts), 3);

        wait_vrise();
        strobe(4'b0100, 4'b0000);
        cnt = 0;
        begin
            logic pv;
            pv = vact();
            while (!disp_on) begin
                @(negedge clk);
                if (!pv && vact()) cnt++;
                pv = vact();
            end
        end
        chk("R9", "frame wraps before display", cnt, 1);
        m_disp = 1;
        wait_vrise();
        measure_frame(-1, 3'd0, 32'd0);

        strobe(4'b1000, 4'b0000);
        chk("R2", "pwm enabled", int'(stage_sts), 15);
        chk("R2", "pwm gate", int'(pwm_en), 1);
        strobe(4'b0000, 4'b1000);
        chk("R3", "pwm disable with clock on err", int'(cmd_err), 1);
        strobe(4'b0000, 4'b0010);
        chk("R3", "sync disable with display on err", int'(cmd_err), 1);
        chk("R3", "status kept after rejects", int'(stage_sts), 15);

        wait_vrise();
        measure_frame(7, 3'd4, (32'(m_rows - 2) << 16) | 32'(m_ppl + 1));
        m_ppl = m_ppl + 2; m_rows = m_rows - 1;
        measure_frame(-1, 3'd0, 32'd0);

        wr(3'd5, 32'h0000_0103);
        m_hpol = 1; m_vpol = 1;
        wait_vrise(); wait_vrise(); wait_vrise();
        measure_frame(-1, 3'd0, 32'd0);

        for (int it = 0; it < 12; it++) begin
            m_div = int'($urandom_range(0, 2)); m_byp = ($urandom_range(0, 3) == 0) ? 1 : 0;
            m_hsw = int'($urandom_range(1, 4)); m_hbp = int'($urandom_range(1, 4));
            m_ppl = int'($urandom_range(1, 8)); m_hfp = int'($urandom_range(1, 4));
            m_vsw = int'($urandom_range(1, 2)); m_vbp = int'($urandom_range(0, 2));
            m_rows = int'($urandom_range(1, 4)); m_vfp = int'($urandom_range(1, 3));
            write_cfg();
            wait_vrise(); wait_vrise(); wait_vrise();
            measure_frame(-1, 3'd0, 32'd0);
            ce_period(p);
            chk("R5", "random pix_ce period", p, ratio());
        end

        wait_vrise();
        strobe(4'b0000, 4'b0100);
        chk("R10", "display held until wrap", int'(disp_on), 1);
        wait_vrise();
        chk("R10", "display off at wrap", int'(disp_on), 0);
        chk("R10", "status after display off", int'(stage_sts), 11);
        m_disp = 0;
        strobe(4'b0000, 4'b0010);
        chk("R10", "sync held after disable", int'(stage_sts[1]), 1);
        cnt = 0;
        while (stage_sts[1] && cnt < 2000) begin
            @(negedge clk);
            cnt++;
        end
        chk("R10", "sync stopped within a frame", int'(cnt <= htot() * vtot() * ratio()), 1);
        chk("R12", "idle level after stop", int'({hsync, vsync}), 3);
        ce_period(p);
        chk("R5", "pix_ce still running", p, ratio());
        strobe(4'b0000, 4'b1000);
        chk("R3", "pwm disable with clock on err", int'(cmd_err), 1);
        strobe(4'b0000, 4'b0001);
        chk("R3", "clock off", int'(stage_sts), 8);
        strobe(4'b0000, 4'b1000);
        chk("R3", "pwm off last", int'(stage_sts), 0);
        chk("R3", "pwm gate off", int'(pwm_en), 0);

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule